// File: doc/BRIEF.md
# External Bus Wait-State and Hold Controller

This block governs one external memory port. Each bus cycle starts with a strobe. The controller then decides the edge on which that cycle may end. It can use a ready input from the outside world, an internal down-counter loaded with a programmed number of wait states, either of the two, or both together. One pulse on a done output marks the end of every accepted cycle.

The same block lets another master take the port. A request may come from a hold pin or from a software bit in the control register. When the hold is granted, the port's drive enable drops, so the pads go high impedance, and an active-low acknowledge is given. A separate inhibit bit blocks only the pin path, so software can still park the port. The control register also holds a bank-size code. That code is decoded into the number of low address bits that lie inside one bank and is shown on an output.

Top module: `xbus_wait_hold`

## Requirements
- R1: After a synchronous reset the control readback is 0x01F: wait mode 3 in bits [1:0], wait count 7 in bits [4:2], and 0 in every other field. `bank_shift` is 8, `holdack_n` and `bus_oe` are 1, and `cyc_done` is 0.
- R2: In wait mode 1 (internal only), a cycle whose start is sampled at edge E ends with `cyc_done` set at edge E+N+1, where N is the wait count in bits [4:2]. This holds for N from 0 to 7.
- R3: In wait mode 0 (external only), the wait count has no effect. The ready pin passes through two flops, and the cycle ends one edge after the synchronized ready is seen high. If ready is already settled high, the cycle ends at E+1. If ready is driven high just after edge E+j, the cycle ends at E+j+3.
- R4: In wait mode 2 (either), a cycle ends at the earlier of the internal count and the synchronized external ready.
- R5: In wait mode 3 (both), a cycle ends only when the internal count has expired and the synchronized ready is high, that is, at the later of the two.
- R6: A start strobe is ignored while a cycle is in progress and while the port is held or a hold is pending. `cyc_done` is a one-cycle pulse and never occurs while the port is held.
- R7: Writing 1 to the software-hold bit (bit 6) while the port is idle drives `holdack_n` and `bus_oe` to 0 one edge after the write edge.
- R8: A rise on `hold_req` is synchronized through two flops. When the port is idle, the hold is granted on the third edge after the pin rises, and it is released on the third edge after the pin falls.
- R9: While the inhibit bit (bit 5) is 1, `hold_req` is ignored: `holdack_n` stays 1. A software hold is still granted.
- R10: Readback bit 7 is 1 exactly while the port is held, from either source. Writes to bit 7 have no effect.
- R11: A hold is never granted in the middle of a bus cycle. A request that arrives during a cycle is granted on the edge after the one that ends the cycle.
- R12: When the hold request drops, `holdack_n` and `bus_oe` return to 1 one edge later.
- R13: The bank code in bits [12:8] sets `bank_shift` to 8 plus the code, with the code clamped at 16. The output updates on the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 13 | Control register write data |
| ctl_rdata | output | 13 | Control register readback, including the hold status in bit 7 |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_done | output | 1 | One-cycle pulse when the accepted cycle may finish |
| ext_rdy | input | 1 | Asynchronous external ready |
| hold_req | input | 1 | Asynchronous external hold request, active high |
| holdack_n | output | 1 | Hold acknowledge, active low |
| bus_oe | output | 1 | Port drive enable; 0 means high impedance |
| bank_shift | output | 5 | Number of address bits inside one bank |

## Verification
The bench measures the exact done latency in each wait mode at wait counts 0 and 7. It also raises ready at chosen offsets, so that a design with one synchronizer flop missing, or with the OR and AND merges swapped, ends cycles on the wrong edge. A start strobe pulsed during a cycle, and again while the port is held, exposes a design that restarts or double-completes. A software hold written during a cycle catches a grant given mid-cycle. The inhibit test separates the pin path from the software path, so a design that gates the wrong source either acknowledges a pin hold or refuses a software one.

// File: rtl/xbh_pkg.sv
package xbh_pkg;

  typedef enum logic [1:0] {
    WM_EXT  = 2'd0,
    WM_INT  = 2'd1,
    WM_ANY  = 2'd2,
    WM_BOTH = 2'd3
  } wait_mode_e;

  // Log2 of bank size from the bank code, clamped at the largest code.
  function automatic int unsigned bank_log2(input int unsigned code,
                                            input int unsigned min_l2,
                                            input int unsigned max_code);
    return ((code > max_code) ? max_code : code) + min_l2;
  endfunction

endpackage

// File: rtl/xbh_sync.sv
module xbh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xbh_wait_engine.sv
module xbh_wait_engine
  import xbh_pkg::*;
#(
  parameter int WCNT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_ok,
  input  wait_mode_e        mode,
  input  logic [WCNT_W-1:0] wcnt,
  input  logic              ext_rdy_s,
  output logic              busy,
  output logic              done
);
  logic [WCNT_W-1:0] cnt;
  logic              int_rdy;
  logic              fin;

  assign int_rdy = (cnt == '0);

  always_comb begin
    case (mode)
      WM_EXT:  fin = ext_rdy_s;
      WM_INT:  fin = int_rdy;
      WM_ANY:  fin = ext_rdy_s | int_rdy;
      default: fin = ext_rdy_s & int_rdy;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= busy & fin;
      if (busy) begin
        if (fin)              busy <= 1'b0;
        else if (cnt != '0)   cnt  <= cnt - 1'b1;
      end else if (start_ok) begin
        busy <= 1'b1;
        cnt  <= wcnt;
      end
    end
  end
endmodule

// File: rtl/xbh_hold_ctrl.sv
module xbh_hold_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic hw_req_s,
  input  logic inhibit,
  input  logic sw_hold,
  input  logic busy,
  output logic want,
  output logic held
);
  assign want = sw_hold | (hw_req_s & ~inhibit);

  always_ff @(posedge clk) begin
    if (rst)       held <= 1'b0;
    else if (held) held <= want;
    else           held <= want & ~busy;
  end
endmodule

// File: rtl/xbus_wait_hold.sv
module xbus_wait_hold
  import xbh_pkg::*;
#(
  parameter int WCNT_W        = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int BANK_CODE_W   = 5,
  parameter int BANK_MIN_LOG2 = 8,
  parameter int BANK_MAX_CODE = 16,
  parameter int SHIFT_W       = 5
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 ctl_we,
  input  logic [2+WCNT_W+3+BANK_CODE_W-1:0]    ctl_wdata,
  output logic [2+WCNT_W+3+BANK_CODE_W-1:0]    ctl_rdata,
  input  logic                                 cyc_start,
  output logic                                 cyc_done,
  input  logic                                 ext_rdy,
  input  logic                                 hold_req,
  output logic                                 holdack_n,
  output logic                                 bus_oe,
  output logic [SHIFT_W-1:0]                   bank_shift
);
  localparam int WC_LSB   = 2;
  localparam int INH_BIT  = WC_LSB + WCNT_W;
  localparam int SWH_BIT  = INH_BIT + 1;
  localparam int STAT_BIT = SWH_BIT + 1;
  localparam int BNK_LSB  = STAT_BIT + 1;
  localparam int CTL_W    = BNK_LSB + BANK_CODE_W;

  localparam logic [CTL_W-1:0] STAT_MASK = CTL_W'(1) << STAT_BIT;
  localparam logic [CTL_W-1:0] WR_MASK   = ~STAT_MASK;
  localparam logic [CTL_W-1:0] RST_VAL   =
    (CTL_W'(WM_BOTH)) | ((CTL_W'((1 << WCNT_W) - 1)) << WC_LSB);

  logic [CTL_W-1:0]  ctl_q;
  wait_mode_e        mode;
  logic [WCNT_W-1:0] wcnt;
  logic              inh_q;
  logic              swh_q;
  logic              rdy_s;
  logic              hreq_s;
  logic              eng_busy;
  logic              hold_want;
  logic              held;
  logic              start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= RST_VAL;
      bank_shift <= SHIFT_W'(BANK_MIN_LOG2);
    end else if (ctl_we) begin
      ctl_q      <= ctl_wdata & WR_MASK;
      bank_shift <= SHIFT_W'(bank_log2(
                      int'(unsigned'(ctl_wdata[BNK_LSB +: BANK_CODE_W])),
                      BANK_MIN_LOG2, BANK_MAX_CODE));
    end
  end

  assign mode  = wait_mode_e'(ctl_q[1:0]);
  assign wcnt  = ctl_q[WC_LSB +: WCNT_W];
  assign inh_q = ctl_q[INH_BIT];
  assign swh_q = ctl_q[SWH_BIT];

  xbh_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(clk), .rst(rst), .d(ext_rdy), .q(rdy_s)
  );

  xbh_sync #(.STAGES(SYNC_STAGES)) u_hold_sync (
    .clk(clk), .rst(rst), .d(hold_req), .q(hreq_s)
  );

  xbh_hold_ctrl u_hold (
    .clk(clk), .rst(rst), .hw_req_s(hreq_s), .inhibit(inh_q),
    .sw_hold(swh_q), .busy(eng_busy), .want(hold_want), .held(held)
  );

  assign start_ok = cyc_start & ~held & ~hold_want;

  xbh_wait_engine #(.WCNT_W(WCNT_W)) u_wait (
    .clk(clk), .rst(rst), .start_ok(start_ok), .mode(mode), .wcnt(wcnt),
    .ext_rdy_s(rdy_s), .busy(eng_busy), .done(cyc_done)
  );

  assign holdack_n = ~held;
  assign bus_oe    = ~held;
  assign ctl_rdata = ctl_q | (held ? STAT_MASK : '0);
endmodule

// File: rtl/xbh_checker.sv
module xbh_checker #(
  parameter int SHIFT_W   = 5,
  parameter int MIN_SHIFT = 8,
  parameter int MAX_SHIFT = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               cyc_done,
  input logic               holdack_n,
  input logic               busy,
  input logic               inh,
  input logic               swh,
  input logic [SHIFT_W-1:0] bank_shift
);
  // R11: a grant only follows an idle cycle
  a_r11_grant_between_cycles: assert property (@(posedge clk) disable iff (rst)
    $fell(holdack_n) |-> $past(!busy));

  // R6: no completion while the port is held
  a_r6_no_done_while_held: assert property (@(posedge clk) disable iff (rst)
    !holdack_n |-> !cyc_done);

  // R6: completion is a single-cycle pulse
  a_r6_done_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> !cyc_done);

  // R9: pin hold cannot be granted while inhibited without software hold
  a_r9_inhibit_blocks_pin: assert property (@(posedge clk) disable iff (rst)
    (inh && !swh && holdack_n) |=> holdack_n);

  // R13: reported bank shift stays in the legal range
  a_r13_shift_range: assert property (@(posedge clk) disable iff (rst)
    (bank_shift >= SHIFT_W'(MIN_SHIFT)) && (bank_shift <= SHIFT_W'(MAX_SHIFT)));
endmodule

bind xbus_wait_hold xbh_checker #(
  .SHIFT_W(SHIFT_W),
  .MIN_SHIFT(BANK_MIN_LOG2),
  .MAX_SHIFT(BANK_MIN_LOG2 + BANK_MAX_CODE)
) u_chk (
  .clk(clk), .rst(rst), .cyc_done(cyc_done), .holdack_n(holdack_n),
  .busy(eng_busy), .inh(inh_q), .swh(swh_q), .bank_shift(bank_shift)
);

// File: tb/xbus_wait_hold_tb.sv
module xbus_wait_hold_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [12:0] ctl_wdata = '0;
  logic [12:0] ctl_rdata;
  logic        cyc_start = 1'b0;
  logic        cyc_done;
  logic        ext_rdy = 1'b0;
  logic        hold_req = 1'b0;
  logic        holdack_n;
  logic        bus_oe;
  logic [4:0]  bank_shift;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xbus_wait_hold dut_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cyc_start(cyc_start), .cyc_done(cyc_done),
    .ext_rdy(ext_rdy), .hold_req(hold_req), .holdack_n(holdack_n),
    .bus_oe(bus_oe), .bank_shift(bank_shift)
  );

  // ---------------- behavioural reference model ----------------
  int m_mode, m_wc, m_inh, m_sh, m_bnk, m_shift, m_cnt;
  bit m_rs1, m_rs2, m_hs1, m_hs2, m_busy, m_done, m_held;

  always @(posedge clk) begin : mdl
    bit want, fin, intr, nheld, nbusy, ndone;
    int ncnt;
    if (rst) begin
      m_mode = 3; m_wc = 7; m_inh = 0; m_sh = 0; m_bnk = 0; m_shift = 8;
      m_cnt = 0; m_rs1 = 0; m_rs2 = 0; m_hs1 = 0; m_hs2 = 0;
      m_busy = 0; m_done = 0; m_held = 0;
    end else begin
      want = (m_sh != 0) || (m_hs2 && (m_inh == 0));
      intr = (m_cnt == 0);
      case (m_mode)
        0: fin = m_rs2;
        1: fin = intr;
        2: fin = m_rs2 || intr;
        default: fin = m_rs2 && intr;
      endcase
      nheld = m_held ? want : (want && !m_busy);
      ndone = m_busy && fin;
      nbusy = m_busy;
      ncnt  = m_cnt;
      if (m_busy) begin
        if (fin) nbusy = 0;
        else if (m_cnt > 0) ncnt = m_cnt - 1;
      end else if (cyc_start && !m_held && !want) begin
        nbusy = 1;
        ncnt  = m_wc;
      end
      if (ctl_we) begin
        m_mode  = int'(ctl_wdata[1:0]);
        m_wc    = int'(ctl_wdata[4:2]);
        m_inh   = int'(ctl_wdata[5]);
        m_sh    = int'(ctl_wdata[6]);
        m_bnk   = int'(ctl_wdata[12:8]);
        m_shift = (m_bnk > 16) ? 24 : 8 + m_bnk;
      end
      m_rs2 = m_rs1; m_rs1 = ext_rdy;
      m_hs2 = m_hs1; m_hs1 = hold_req;
      m_held = nheld; m_done = ndone; m_busy = nbusy; m_cnt = ncnt;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R6 cyc_done vs model", int'(cyc_done), int'(m_done));
      check("R7 holdack_n vs model", int'(holdack_n), int'(!m_held));
      check("R7 bus_oe vs model", int'(bus_oe), int'(!m_held));
      check("R10 ctl_rdata vs model", int'(ctl_rdata),
            (m_bnk << 8) | (int'(m_held) << 7) | (m_sh << 6) | (m_inh << 5) |
            (m_wc << 2) | m_mode);
      check("R13 bank_shift vs model", int'(bank_shift), m_shift);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_ctl(input int md, input int wc, input int inh,
                         input int sh, input int bnk, input int stat);
    ctl_we    = 1'b1;
    ctl_wdata = 13'((bnk << 8) | (stat << 7) | (sh << 6) | (inh << 5) |
                    (wc << 2) | md);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // lat = index of the edge (start edge is 0) at which done is set
  task automatic run_cyc(input int rdy_at, output int lat);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    lat = 0;
    if (rdy_at == 0) ext_rdy = 1'b1;
    while (lat < 40) begin
      @(negedge clk);
      lat++;
      if (cyc_done) break;
      if (lat == rdy_at) ext_rdy = 1'b1;
    end
    ext_rdy = 1'b0;
    idle(4);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int lat;
    int nd;
    int first;
    bit bad;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 reset readback", int'(ctl_rdata), 'h01F);
    check("R1 reset bank_shift", int'(bank_shift), 8);
    check("R1 reset holdack_n", int'(holdack_n), 1);
    check("R1 reset bus_oe", int'(bus_oe), 1);
    check("R1 reset cyc_done", int'(cyc_done), 0);

    // R2 internal only
    set_ctl(1, 0, 0, 0, 0, 0); run_cyc(-1, lat); check("R2 wc0", lat, 1);
    set_ctl(1, 7, 0, 0, 0, 0); run_cyc(-1, lat); check("R2 wc7", lat, 8);
    set_ctl(1, 3, 0, 0, 0, 0); run_cyc(-1, lat); check("R2 wc3", lat, 4);

    // R3 external only
    set_ctl(0, 7, 0, 0, 0, 0);
    ext_rdy = 1'b1; idle(3);
    run_cyc(-1, lat); check("R3 ready settled", lat, 1);
    run_cyc(2, lat);  check("R3 ready late", lat, 5);
    run_cyc(0, lat);  check("R3 ready at start", lat, 3);

    // R4 either
    set_ctl(2, 6, 0, 0, 0, 0);
    run_cyc(1, lat);  check("R4 ext first", lat, 4);
    run_cyc(-1, lat); check("R4 int only", lat, 7);

    // R5 both
    set_ctl(3, 2, 0, 0, 0, 0);
    run_cyc(4, lat);  check("R5 ext later", lat, 7);
    set_ctl(3, 5, 0, 0, 0, 0);
    ext_rdy = 1'b1; idle(3);
    run_cyc(-1, lat); check("R5 int later", lat, 6);

    // R6 start while busy
    set_ctl(1, 4, 0, 0, 0, 0);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    nd = 0; first = 0;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      cyc_start = (k == 2);
      if (cyc_done) begin
        nd++;
        if (first == 0) first = k;
      end
    end
    cyc_start = 1'b0;
    check("R6 one done while busy", nd, 1);
    check("R6 done edge", first, 5);

    // R7 software hold, R10 status
    set_ctl(1, 2, 0, 1, 0, 0);
    check("R7 holdack_n before grant", int'(holdack_n), 1);
    @(negedge clk);
    check("R7 holdack_n granted", int'(holdack_n), 0);
    check("R7 bus_oe granted", int'(bus_oe), 0);
    check("R10 status held", int'(ctl_rdata[7]), 1);
    // R6 start while held
    cyc_start = 1'b1; @(negedge clk); cyc_start = 1'b0;
    nd = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (cyc_done) nd++;
    end
    check("R6 start ignored while held", nd, 0);
    // R12 release
    set_ctl(1, 2, 0, 0, 0, 0);
    check("R12 still held on write edge", int'(holdack_n), 0);
    @(negedge clk);
    check("R12 released", int'(holdack_n), 1);
    check("R12 bus_oe back", int'(bus_oe), 1);

    // R10 write to status bit has no effect
    set_ctl(1, 2, 0, 0, 0, 1);
    check("R10 status write ignored", int'(ctl_rdata[7]), 0);
    check("R10 holdack after status write", int'(holdack_n), 1);

    // R8 pin hold through synchronizer
    hold_req = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 not yet granted", int'(holdack_n), 1);
    @(negedge clk);
    check("R8 granted", int'(holdack_n), 0);
    hold_req = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 still held", int'(holdack_n), 0);
    @(negedge clk);
    check("R8 released", int'(holdack_n), 1);

    // R9 inhibit
    set_ctl(1, 2, 1, 0, 0, 0);
    hold_req = 1'b1;
    bad = 1'b0;
    repeat (8) begin
      @(negedge clk);
      if (!holdack_n) bad = 1'b1;
    end
    check("R9 pin hold ignored", int'(bad), 0);
    set_ctl(1, 2, 1, 1, 0, 0);
    @(negedge clk);
    check("R9 software hold still granted", int'(holdack_n), 0);
    hold_req = 1'b0;
    set_ctl(1, 2, 0, 0, 0, 0);
    idle(4);

    // R11 hold requested mid-cycle
    set_ctl(1, 5, 0, 0, 0, 0);
    cyc_start = 1'b1; @(negedge clk); cyc_start = 1'b0;
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 13'((1 << 6) | (5 << 2) | 1);
    bad = 1'b0;
    for (int k = 2; k <= 6; k++) begin
      @(negedge clk);
      ctl_we = 1'b0;
      if (!holdack_n) bad = 1'b1;
      if (k == 6) check("R11 done edge", int'(cyc_done), 1);
    end
    check("R11 no grant mid-cycle", int'(bad), 0);
    @(negedge clk);
    check("R11 grant after done", int'(holdack_n), 0);
    set_ctl(1, 5, 0, 0, 0, 0);
    idle(2);

    // R13 bank decode
    set_ctl(3, 7, 0, 0, 5, 0);  check("R13 code 5", int'(bank_shift), 13);
    set_ctl(3, 7, 0, 0, 16, 0); check("R13 code 16", int'(bank_shift), 24);
    set_ctl(3, 7, 0, 0, 31, 0); check("R13 code 31 clamp", int'(bank_shift), 24);
    set_ctl(3, 7, 0, 0, 0, 0);  check("R13 code 0", int'(bank_shift), 8);
    idle(2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule